// File: doc/BRIEF.md
# Sixteen-Bit Instruction Format Decoder

This block is a purely combinational front-end decoder for a 16-bit instruction set with three encodings: a two-operand arithmetic/logic form, a one-operand form and a short PC-relative branch. For each instruction word it names the encoding and splits out the fields. These fields are the operation code, the register numbers, the addressing-mode fields, the byte-or-word width flag, and the branch condition with its displacement. It also flags words that fit none of the encodings.

A fetch unit uses the block to learn, before it reads any operand, how many extension words follow the instruction and which operand each one belongs to. The count depends on the addressing modes and also on the register named. Some register and mode pairs make constants or immediates, so they change the count. Fetching the extension words, executing the operation and updating the program counter are done elsewhere.

Top module: `insnDecoder`

## Requirements
- R1: The format output `fmt` is 3 (jump) when bits 15..13 are 001, 1 (two-operand) when bits 15..14 are not 00, and 2 (one-operand) when bits 15..10 are 000100.
- R2: Any other word (top nibble 0000, or top nibble 0001 without 000100 in bits 15..10) sets `illegal`=1 and `fmt`=0, and drives every other output to zero. `illegal` is 0 for every legal word.
- R3: For a two-operand word, `opcode`=bits 15..12, `srcReg`=bits 11..8, `srcMode`=bits 5..4, `dstReg`=bits 3..0 and `dstMode`={0, bit 7}. `jumpCond` and `jumpDisp` are 0.
- R4: For a one-operand word, `opcode`={0, bits 9..7}, `dstReg`=bits 3..0 and `dstMode`=bits 5..4. `srcReg`, `srcMode`, `jumpCond` and `jumpDisp` are 0.
- R5: For a jump word, `jumpCond`=bits 12..10 and `jumpDisp` is the 10-bit offset in bits 9..0, sign-extended to 16 bits and multiplied by two. All register, mode, opcode and extension outputs are 0.
- R6: `byteOp` equals bit 6 for both operand formats (1 = byte, 0 = word) and is 0 for jumps.
- R7: In the two-operand form, `srcExt`=1 exactly when the source mode is 01 and the source register is not 3, or when the source mode is 11 and the source register is 0. Register 2 in modes 10/11 and register 3 in every mode need no word.
- R8: In the two-operand form, `dstExt`=1 exactly when bit 7 (the indexed destination mode) is 1, whatever the register.
- R9: `extCount` equals `srcExt`+`dstExt`. `dstExtSlot` is 1 (the destination word is second) only when both words are present; otherwise it is 0, so the source word always comes first.
- R10: In the one-operand form, `srcExt`=0 and `dstExt` follows the R7 rule applied to bits 3..0 and 5..4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| instr | input | 16 | Instruction word to decode |
| fmt | output | 2 | Format tag: 0 none, 1 two-operand, 2 one-operand, 3 jump |
| illegal | output | 1 | Word matches no encoding |
| opcode | output | 4 | Operation code |
| srcReg | output | 4 | Source register number |
| srcMode | output | 2 | Source addressing mode |
| dstReg | output | 4 | Destination / operand register number |
| dstMode | output | 2 | Destination addressing mode |
| byteOp | output | 1 | 1 = byte operation, 0 = word operation |
| jumpCond | output | 3 | Branch condition code |
| jumpDisp | output | 16 | Signed byte displacement of the branch |
| srcExt | output | 1 | An extension word is needed for the source |
| dstExt | output | 1 | An extension word is needed for the destination |
| extCount | output | 2 | Number of extension words after the instruction |
| dstExtSlot | output | 1 | Position of the destination word (0 first, 1 second) |

## Verification
The bench applies all 65536 instruction words in order and compares every output with a behavioural model in the bench. The sweep covers every prefix boundary between the illegal, one-operand, jump and two-operand ranges. It also covers every register and mode pair, which separates the constant registers 2 and 3 from the immediate case on register 0 and from plain indexed operands. Words with both an indexed source and an indexed destination show whether the word order is right. Jump words with the top offset bit set show whether the displacement is sign-extended and doubled.

// File: rtl/insnDecPkg.sv
package insnDecPkg;
  localparam int INSTR_W = 16;
  localparam int OPC_W   = 4;
  localparam int REG_W   = 4;
  localparam int MODE_W  = 2;
  localparam int COND_W  = 3;
  localparam int OFS_W   = 10;
  localparam int EXT_W   = 2;
  localparam int DISP_SIGN_W = INSTR_W - OFS_W - 1;

  typedef enum logic [1:0] {
    FMT_NONE   = 2'd0,
    FMT_DOUBLE = 2'd1,
    FMT_SINGLE = 2'd2,
    FMT_JUMP   = 2'd3
  } insnFmt_e;

  typedef struct packed {
    logic selDouble;
    logic selSingle;
    logic selJump;
  } decStrobes_t;

  localparam logic [REG_W-1:0]  REG_PC  = 4'd0;
  localparam logic [REG_W-1:0]  REG_CG2 = 4'd3;
  localparam logic [MODE_W-1:0] MODE_IDX = 2'd1;
  localparam logic [MODE_W-1:0] MODE_INC = 2'd3;
endpackage

// File: rtl/insnDecCtrl.sv
module insnDecCtrl
  import insnDecPkg::*;
(
  input  logic [INSTR_W-1:0] instr,
  output decStrobes_t        strobes,
  output insnFmt_e           fmt,
  output logic               illegal
);
  logic isJump, isDouble, isSingle;

  always_comb begin
    isJump   = (instr[15:13] == 3'b001);
    isDouble = (instr[15:14] != 2'b00);
    isSingle = (instr[15:10] == 6'b000100);

    strobes.selDouble = isDouble;
    strobes.selSingle = isSingle;
    strobes.selJump   = isJump;

    if (isDouble)      fmt = FMT_DOUBLE;
    else if (isJump)   fmt = FMT_JUMP;
    else if (isSingle) fmt = FMT_SINGLE;
    else               fmt = FMT_NONE;

    illegal = !(isDouble || isJump || isSingle);
  end
endmodule

// File: rtl/insnOperandWords.sv
module insnOperandWords
  import insnDecPkg::*;
#(
  parameter int RW = REG_W,
  parameter int MW = MODE_W
) (
  input  logic [RW-1:0] regNum,
  input  logic [MW-1:0] mode,
  output logic          needsWord
);
  always_comb begin
    unique case (mode)
      MODE_IDX: needsWord = (regNum != REG_CG2);
      MODE_INC: needsWord = (regNum == REG_PC);
      default:  needsWord = 1'b0;
    endcase
  end
endmodule

// File: rtl/insnDecData.sv
module insnDecData
  import insnDecPkg::*;
(
  input  logic [INSTR_W-1:0] instr,
  input  decStrobes_t        strobes,
  output logic [OPC_W-1:0]   opcode,
  output logic [REG_W-1:0]   srcReg,
  output logic [MODE_W-1:0]  srcMode,
  output logic [REG_W-1:0]   dstReg,
  output logic [MODE_W-1:0]  dstMode,
  output logic               byteOp,
  output logic [COND_W-1:0]  jumpCond,
  output logic [INSTR_W-1:0] jumpDisp,
  output logic               srcExt,
  output logic               dstExt,
  output logic [EXT_W-1:0]   extCount,
  output logic               dstExtSlot
);
  logic srcNeed, sglNeed;
  logic [OFS_W-1:0] ofs;

  assign ofs = instr[OFS_W-1:0];

  insnOperandWords #(.RW(REG_W), .MW(MODE_W)) i_srcWords (
    .regNum   (instr[11:8]),
    .mode     (instr[5:4]),
    .needsWord(srcNeed)
  );

  insnOperandWords #(.RW(REG_W), .MW(MODE_W)) i_sglWords (
    .regNum   (instr[3:0]),
    .mode     (instr[5:4]),
    .needsWord(sglNeed)
  );

  always_comb begin
    opcode   = '0;
    srcReg   = '0;
    srcMode  = '0;
    dstReg   = '0;
    dstMode  = '0;
    byteOp   = 1'b0;
    jumpCond = '0;
    jumpDisp = '0;
    srcExt   = 1'b0;
    dstExt   = 1'b0;
    if (strobes.selDouble) begin
      opcode  = instr[15:12];
      srcReg  = instr[11:8];
      dstMode = {1'b0, instr[7]};
      byteOp  = instr[6];
      srcMode = instr[5:4];
      dstReg  = instr[3:0];
      srcExt  = srcNeed;
      dstExt  = instr[7];
    end else if (strobes.selJump) begin
      jumpCond = instr[12:10];
      jumpDisp = {{DISP_SIGN_W{ofs[OFS_W-1]}}, ofs, 1'b0};
    end else if (strobes.selSingle) begin
      opcode  = {1'b0, instr[9:7]};
      byteOp  = instr[6];
      dstMode = instr[5:4];
      dstReg  = instr[3:0];
      dstExt  = sglNeed;
    end
  end

  always_comb begin
    extCount   = {1'b0, srcExt} + {1'b0, dstExt};
    dstExtSlot = srcExt & dstExt;
  end
endmodule

// File: rtl/insnDecoder.sv
module insnDecoder
  import insnDecPkg::*;
(
  input  logic [15:0] instr,
  output logic [1:0]  fmt,
  output logic        illegal,
  output logic [3:0]  opcode,
  output logic [3:0]  srcReg,
  output logic [1:0]  srcMode,
  output logic [3:0]  dstReg,
  output logic [1:0]  dstMode,
  output logic        byteOp,
  output logic [2:0]  jumpCond,
  output logic [15:0] jumpDisp,
  output logic        srcExt,
  output logic        dstExt,
  output logic [1:0]  extCount,
  output logic        dstExtSlot
);
  decStrobes_t strobes;
  insnFmt_e    fmtTag;

  insnDecCtrl i_ctrl (
    .instr  (instr),
    .strobes(strobes),
    .fmt    (fmtTag),
    .illegal(illegal)
  );

  insnDecData i_data (
    .instr     (instr),
    .strobes   (strobes),
    .opcode    (opcode),
    .srcReg    (srcReg),
    .srcMode   (srcMode),
    .dstReg    (dstReg),
    .dstMode   (dstMode),
    .byteOp    (byteOp),
    .jumpCond  (jumpCond),
    .jumpDisp  (jumpDisp),
    .srcExt    (srcExt),
    .dstExt    (dstExt),
    .extCount  (extCount),
    .dstExtSlot(dstExtSlot)
  );

  assign fmt = fmtTag;
endmodule

// File: rtl/insnDecoderChecker.sv
module insnDecoderChecker (
  input logic [15:0] instr,
  input logic [1:0]  fmt,
  input logic        illegal,
  input logic [3:0]  opcode,
  input logic [1:0]  srcMode,
  input logic [3:0]  srcReg,
  input logic [15:0] jumpDisp,
  input logic        srcExt,
  input logic        dstExt,
  input logic [1:0]  extCount,
  input logic        dstExtSlot
);
  always_comb begin
    // R2: illegal flag agrees with the format tag and silences the rest
    p_illegal_quiet_r2: assert (!illegal || (fmt == 2'd0 && extCount == 2'd0 && opcode == 4'd0));
    // R1: legal words always receive a format tag
    p_fmt_tagged_r1: assert (illegal || fmt != 2'd0);
    // R9: word count agrees with the per-operand flags
    p_count_r9: assert (extCount == 2'({1'b0, srcExt} + {1'b0, dstExt}));
    // R9: destination word is second only behind a source word
    p_order_r9: assert (!dstExtSlot || (srcExt && dstExt));
    // R7: register 3 never needs a source word
    p_const_src_r7: assert (!(fmt == 2'd1 && srcReg == 4'd3) || !srcExt);
    // R5: branch displacement is even and sign-consistent
    p_disp_r5: assert (fmt != 2'd3 || (jumpDisp[0] == 1'b0 && jumpDisp[15] == instr[9]));
    // R10: one-operand words never take a source word
    p_single_nosrc_r10: assert (fmt != 2'd2 || (!srcExt && srcMode == 2'd0));
  end
endmodule

bind insnDecoder insnDecoderChecker i_checker (
  .instr     (instr),
  .fmt       (fmt),
  .illegal   (illegal),
  .opcode    (opcode),
  .srcMode   (srcMode),
  .srcReg    (srcReg),
  .jumpDisp  (jumpDisp),
  .srcExt    (srcExt),
  .dstExt    (dstExt),
  .extCount  (extCount),
  .dstExtSlot(dstExtSlot)
);

// File: tb/test_insnDecoder.sv
module test_insnDecoder;
  localparam time CLK_PERIOD = 10ns;
  localparam int  WATCHDOG_CYCLES = 150000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [15:0] instr = 16'h0000;

  logic [1:0]  fmt;
  logic        illegal;
  logic [3:0]  opcode, srcReg, dstReg;
  logic [1:0]  srcMode, dstMode, extCount;
  logic        byteOp, srcExt, dstExt, dstExtSlot;
  logic [2:0]  jumpCond;
  logic [15:0] jumpDisp;

  int checks = 0;
  int fails = 0;
  int cycles = 0;
  bit done = 1'b0;

  // expected values
  int eFmt, eIll, eOpc, eSrcReg, eSrcMode, eDstReg, eDstMode, eByte;
  int eCond, eDisp, eSrcExt, eDstExt, eCount, eSlot;

  always #(CLK_PERIOD/2) clk = ~clk;

  insnDecoder i_insnDecoder (
    .instr(instr), .fmt(fmt), .illegal(illegal), .opcode(opcode),
    .srcReg(srcReg), .srcMode(srcMode), .dstReg(dstReg), .dstMode(dstMode),
    .byteOp(byteOp), .jumpCond(jumpCond), .jumpDisp(jumpDisp),
    .srcExt(srcExt), .dstExt(dstExt), .extCount(extCount), .dstExtSlot(dstExtSlot)
  );

  function automatic int wordsFor(int r, int m);
    if (m == 1) return (r == 3) ? 0 : 1;
    if (m == 3) return (r == 0) ? 1 : 0;
    return 0;
  endfunction

  task automatic model(input int w);
    int top3, top6, ofs;
    top3 = w / 8192;
    top6 = w / 1024;
    eFmt = 0; eIll = 0; eOpc = 0; eSrcReg = 0; eSrcMode = 0; eDstReg = 0;
    eDstMode = 0; eByte = 0; eCond = 0; eDisp = 0; eSrcExt = 0; eDstExt = 0;
    if (w >= 16384) begin
      eFmt = 1;
      eOpc = w / 4096;
      eSrcReg = (w / 256) % 16;
      eDstMode = (w / 128) % 2;
      eByte = (w / 64) % 2;
      eSrcMode = (w / 16) % 4;
      eDstReg = w % 16;
      eSrcExt = wordsFor(eSrcReg, eSrcMode);
      eDstExt = eDstMode;
    end else if (top3 == 1) begin
      eFmt = 3;
      eCond = (w / 1024) % 8;
      ofs = w % 1024;
      if (ofs >= 512) ofs = ofs - 1024;
      eDisp = (ofs * 2) & 16'hFFFF;
    end else if (top6 == 4) begin
      eFmt = 2;
      eOpc = (w / 128) % 8;
      eByte = (w / 64) % 2;
      eDstMode = (w / 16) % 4;
      eDstReg = w % 16;
      eDstExt = wordsFor(eDstReg, eDstMode);
    end else begin
      eIll = 1;
    end
    eCount = eSrcExt + eDstExt;
    eSlot = (eSrcExt == 1 && eDstExt == 1) ? 1 : 0;
  endtask

  task automatic chk(input string tag, input string name, input int act, input int exp, input int w);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s instr=%04h actual=%0d expected=%0d", tag, name, w, act, exp);
    end
  endtask

  function automatic string fieldTag();
    if (eIll == 1) return "R2";
    if (eFmt == 1) return "R3";
    if (eFmt == 2) return "R4";
    return "R5";
  endfunction

  task automatic compareAll(input int w);
    string ft;
    model(w);
    ft = fieldTag();
    chk("R1", "fmt", int'(fmt), eFmt, w);
    chk("R2", "illegal", int'(illegal), eIll, w);
    chk(ft, "opcode", int'(opcode), eOpc, w);
    chk(ft, "srcReg", int'(srcReg), eSrcReg, w);
    chk(ft, "srcMode", int'(srcMode), eSrcMode, w);
    chk(ft, "dstReg", int'(dstReg), eDstReg, w);
    chk(ft, "dstMode", int'(dstMode), eDstMode, w);
    chk("R6", "byteOp", int'(byteOp), eByte, w);
    chk("R5", "jumpCond", int'(jumpCond), eCond, w);
    chk("R5", "jumpDisp", int'(jumpDisp), eDisp, w);
    chk((eFmt == 2) ? "R10" : "R7", "srcExt", int'(srcExt), eSrcExt, w);
    chk((eFmt == 2) ? "R10" : "R8", "dstExt", int'(dstExt), eDstExt, w);
    chk("R9", "extCount", int'(extCount), eCount, w);
    chk("R9", "dstExtSlot", int'(dstExtSlot), eSlot, w);
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R2: state held during reset, all-zero word is illegal
    chk("R2", "reset illegal", int'(illegal), 1, 0);
    chk("R2", "reset extCount", int'(extCount), 0, 0);
    rst = 1'b0;
    // directed corner: both indexed, R9 order (source first)
    @(posedge clk); instr = 16'h4596;
    @(negedge clk);
    chk("R9", "both words count", int'(extCount), 2, 16'h4596);
    chk("R9", "dst second", int'(dstExtSlot), 1, 16'h4596);
    // R7: register 2 mode 10 is a constant
    @(posedge clk); instr = 16'h4220;
    @(negedge clk);
    chk("R7", "cg reg2 mode10", int'(srcExt), 0, 16'h4220);
    // R5: most negative offset
    @(posedge clk); instr = 16'h3E00;
    @(negedge clk);
    chk("R5", "disp min", int'(jumpDisp), 16'hFC00, 16'h3E00);
    // full sweep, compared on every clock
    for (int w = 0; w < 65536; w++) begin
      @(posedge clk);
      instr = 16'(w);
      @(negedge clk);
      compareAll(w);
    end
    finishRun();
  end

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles >= WATCHDOG_CYCLES && !done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired after %0d cycles expected completion", cycles);
      finishRun();
    end
  end
endmodule